// File: doc/BRIEF.md
# Dual-Channel Asynchronous Serial Frame Monitor

This block listens, without driving anything, to two asynchronous serial lines: a receive line and a transmit line. Each line has its own decoder. A decoder waits for a falling edge on its idle-high line, samples every bit at its centre, assembles a data word of 5 to 9 bits in either bit order, and checks an optional parity bit and the single stop bit. What it observes is reported as a stream of tagged events.

Both decoders share one set of static configuration inputs: the bit period in clocks, the word width, the bit order and the parity mode. These may only change while both lines are idle. Events from the two decoders merge into one valid/ready stream. Each event has a 3-bit code, a direction tag and a 9-bit payload. A consumer such as a trace buffer or a protocol checker drains the stream.

Top module: `uartmon_top`

## Requirements
- R1: Both lines idle high. A frame starts only on a high-to-low transition of the synchronized line, so a line held high produces no events.
- R2: Let the falling edge be elapsed time 0 and H = `cfg_cpb >> 1`. Frame bit n is sampled H + n·`cfg_cpb` clocks after the edge. Bit 0 is the start bit, bits 1..N are data, then the parity bit if enabled, then the stop bit. `cfg_cpb` must be at least 2.
- R3: `cfg_nbits` sets the word width N, from 5 to 9. A DATA event payload never has a bit set at position N or above.
- R4: With `cfg_msb_first` = 0, the first data bit on the line lands in payload bit 0.
- R5: With `cfg_msb_first` = 1, the first data bit on the line lands in payload bit N-1.
- R6: `cfg_parity` selects the parity mode: 0 none, 1 odd, 2 even, 3 always-zero, 4 always-one. Odd and even count the ones in the data bits plus the parity bit. A correct parity bit gives code 2 (PAR_OK) and a wrong one gives code 3 (PAR_ERR). In both cases the payload is the sampled parity bit.
- R7: With parity mode none, no parity bit is sampled and the stop bit is taken at position N+1.
- R8: A start bit sampled high gives code 5 (BAD_START) with payload 1. The rest of the frame is still decoded.
- R9: A stop bit sampled high gives code 4 (STOP) with payload 1. A stop bit sampled low gives code 6 (FRAME_ERR) with payload 0. The decoder then waits for a new falling edge in either case.
- R10: Events from the receive line carry direction 0 and events from the transmit line carry direction 1. The two decoders share no state, so traffic on one line never changes what the other reports.
- R11: The output is held, unchanged, while `evt_valid` is high and `evt_ready` is low. After reset `evt_valid` is low. When both channels have an event pending and no transfer is stalled, the receive channel's event is presented first.
- R12: A start bit sampled low gives code 0 (START) with payload 0. A complete data word gives code 1 (DATA). Each frame yields, in order: a start event, a DATA event, a parity event if parity is enabled, and a stop event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Receive serial line, asynchronous |
| tx_line | input | 1 | Transmit serial line, asynchronous |
| cfg_cpb | input | CPB_W | Bit period in clock cycles |
| cfg_nbits | input | 4 | Data word width, 5 to 9 |
| cfg_msb_first | input | 1 | 1: most significant bit first on the line |
| cfg_parity | input | 3 | Parity mode code |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_valid | output | 1 | Event present |
| evt_code | output | 3 | Event code |
| evt_dir | output | 1 | 0 receive line, 1 transmit line |
| evt_data | output | 9 | Event payload |

## Verification
The bench builds the top with the default `CPB_W` of 16 and sets `cfg_cpb` to 16 clocks. With a half-bit offset of 8, the bench can place a glitch of a few cycles inside the start bit that the decoder sees as a high start sample, and the frames stay short enough for many configurations to run. The bench drops `evt_ready` one cycle in five, so events wait in the holding slots. It also drives both lines with the same timing so that both decoders emit events in the same cycle, which exercises the receive-first ordering. The runs cover word widths 5, 6, 7, 8 and 9 and every parity mode.

// File: rtl/uartmon_pkg.sv
package uartmon_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_EVEN = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        EV_START     = 3'd0,
        EV_DATA      = 3'd1,
        EV_PAR_OK    = 3'd2,
        EV_PAR_ERR   = 3'd3,
        EV_STOP      = 3'd4,
        EV_BAD_START = 3'd5,
        EV_FRAME_ERR = 3'd6
    } ev_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } ch_state_e;

    typedef struct packed {
        ev_code_e            code;
        logic                dir;
        logic [WORD_W-1:0]   data;
    } mon_ev_t;

    // True when the sampled parity bit agrees with the configured mode.
    function automatic logic parity_good(par_mode_e m, logic p, logic [WORD_W-1:0] w);
        logic r;
        case (m)
            PAR_ODD:  r = ^{w, p};
            PAR_EVEN: r = ~(^{w, p});
            PAR_ZERO: r = ~p;
            PAR_ONE:  r = p;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uartmon_sync.sv
module uartmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uartmon_chan.sv
module uartmon_chan
    import uartmon_pkg::*;
#(
    parameter int   CPB_W = 16,
    parameter logic DIR   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic [CPB_W-1:0] cfg_cpb,
    input  logic [3:0]       cfg_nbits,
    input  logic             cfg_msb_first,
    input  par_mode_e        cfg_parity,
    output logic             ev_v,
    output mon_ev_t          ev
);
    localparam int TW = CPB_W + 4;

    ch_state_e         state;
    logic              prev;
    logic [TW-1:0]     cnt;
    logic [TW-1:0]     target;
    logic [3:0]        bitn;
    logic [WORD_W-1:0] word;

    logic              hit;
    logic              is_start, is_data, is_last_data, is_par;
    logic [WORD_W-1:0] word_nxt;
    logic [3:0]        par_pos;

    always_comb begin
        hit          = (state == ST_FRAME) && (cnt == target);
        par_pos      = cfg_nbits + 4'd1;
        is_start     = (bitn == 4'd0);
        is_data      = !is_start && (bitn <= cfg_nbits);
        is_last_data = (bitn == cfg_nbits);
        is_par       = (cfg_parity != PAR_NONE) && (bitn == par_pos);
        if (cfg_msb_first)
            word_nxt = {word[WORD_W-2:0], line};
        else
            word_nxt = (word >> 1) | (WORD_W'(line) << (cfg_nbits - 4'd1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            prev   <= 1'b1;
            cnt    <= '0;
            target <= '0;
            bitn   <= '0;
            word   <= '0;
            ev_v   <= 1'b0;
            ev     <= '0;
        end else begin
            prev <= line;
            ev_v <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (prev && !line) begin
                        state  <= ST_FRAME;
                        cnt    <= TW'(1);
                        target <= TW'(cfg_cpb >> 1);
                        bitn   <= '0;
                        word   <= '0;
                    end
                end
                default: begin
                    cnt <= cnt + TW'(1);
                    if (hit) begin
                        target  <= target + TW'(cfg_cpb);
                        bitn    <= bitn + 4'd1;
                        ev.dir  <= DIR;
                        if (is_start) begin
                            ev_v    <= 1'b1;
                            ev.code <= line ? EV_BAD_START : EV_START;
                            ev.data <= WORD_W'(line);
                        end else if (is_data) begin
                            word <= word_nxt;
                            if (is_last_data) begin
                                ev_v    <= 1'b1;
                                ev.code <= EV_DATA;
                                ev.data <= word_nxt;
                            end
                        end else if (is_par) begin
                            ev_v    <= 1'b1;
                            ev.code <= parity_good(cfg_parity, line, word) ? EV_PAR_OK : EV_PAR_ERR;
                            ev.data <= WORD_W'(line);
                        end else begin
                            ev_v    <= 1'b1;
                            ev.code <= line ? EV_STOP : EV_FRAME_ERR;
                            ev.data <= WORD_W'(line);
                            state   <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uartmon_arb.sv
module uartmon_arb
    import uartmon_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_v  [NCH],
    input  mon_ev_t       in_ev [NCH],
    input  logic          out_ready,
    output mon_ev_t       out_ev,
    output logic [NCH-1:0] pend_o
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] pend;
    mon_ev_t        slot [NCH];
    logic [SEL_W-1:0] sel_q, gsel, prio_sel;
    logic           locked;

    // Lowest index wins; a stalled grant stays put until it is taken.
    always_comb begin
        prio_sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) prio_sel = SEL_W'(i);
        end
        gsel = locked ? sel_q : prio_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            sel_q  <= '0;
            locked <= 1'b0;
            for (int i = 0; i < NCH; i++) slot[i] <= '0;
        end else begin
            sel_q  <= gsel;
            locked <= (|pend) && !out_ready;
            for (int i = 0; i < NCH; i++) begin
                if (in_v[i]) begin
                    slot[i] <= in_ev[i];
                    pend[i] <= 1'b1;
                end else if (out_ready && (gsel == SEL_W'(i))) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end

    assign out_ev = slot[gsel];
    assign pend_o = pend;
endmodule

// File: rtl/uartmon_top.sv
module uartmon_top
    import uartmon_pkg::*;
#(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic             tx_line,
    input  logic [CPB_W-1:0] cfg_cpb,
    input  logic [3:0]       cfg_nbits,
    input  logic             cfg_msb_first,
    input  logic [2:0]       cfg_parity,
    input  logic             evt_ready,
    output logic             evt_valid,
    output logic [2:0]       evt_code,
    output logic             evt_dir,
    output logic [8:0]       evt_data
);
    localparam int NCH = 2;

    logic           lines  [NCH];
    logic           synced [NCH];
    logic           ch_v   [NCH];
    mon_ev_t        ch_ev  [NCH];
    mon_ev_t        out_ev;
    logic [NCH-1:0] arb_pend;

    assign lines[0] = rx_line;
    assign lines[1] = tx_line;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        uartmon_sync #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (lines[g]),
            .q   (synced[g])
        );
        uartmon_chan #(.CPB_W(CPB_W), .DIR(g == 1)) u_chan (
            .clk           (clk),
            .rst           (rst),
            .line          (synced[g]),
            .cfg_cpb       (cfg_cpb),
            .cfg_nbits     (cfg_nbits),
            .cfg_msb_first (cfg_msb_first),
            .cfg_parity    (par_mode_e'(cfg_parity)),
            .ev_v          (ch_v[g]),
            .ev            (ch_ev[g])
        );
    end

    uartmon_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .in_v      (ch_v),
        .in_ev     (ch_ev),
        .out_ready (evt_ready),
        .out_ev    (out_ev),
        .pend_o    (arb_pend)
    );

    assign evt_valid = |arb_pend;
    assign evt_code  = out_ev.code;
    assign evt_dir   = out_ev.dir;
    assign evt_data  = out_ev.data;
endmodule

// File: rtl/uartmon_checker.sv
module uartmon_checker (
    input logic       clk,
    input logic       rst,
    input logic       evt_valid,
    input logic       evt_ready,
    input logic [2:0] evt_code,
    input logic       evt_dir,
    input logic [8:0] evt_data,
    input logic [3:0] cfg_nbits,
    input logic [1:0] pend
);
    logic stall_q;
    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= evt_valid && !evt_ready;
    end

    a_r11_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> evt_valid);

    a_r11_hold_content: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> ($stable(evt_code) && $stable(evt_dir) && $stable(evt_data)));

    a_r11_rx_first: assert property (@(posedge clk) disable iff (rst)
        (pend == 2'b11 && !stall_q) |-> (evt_dir == 1'b0));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == 3'd1) |-> ((evt_data >> cfg_nbits) == 9'd0));

    a_r9_stop_payload: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == 3'd4) |-> (evt_data == 9'd1));

    a_r9_ferr_payload: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == 3'd6) |-> (evt_data == 9'd0));

    a_r8_bad_start_payload: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == 3'd5) |-> (evt_data == 9'd1));

    a_r12_start_payload: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == 3'd0) |-> (evt_data == 9'd0));

    a_r12_code_legal: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code != 3'd7));
endmodule

bind uartmon_top uartmon_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_code  (evt_code),
    .evt_dir   (evt_dir),
    .evt_data  (evt_data),
    .cfg_nbits (cfg_nbits),
    .pend      (arb_pend)
);

// File: tb/uartmon_top_bench.sv
module uartmon_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic        tx_line = 1'b1;
    logic [15:0] cfg_cpb = 16'd16;
    logic [3:0]  cfg_nbits = 4'd8;
    logic        cfg_msb_first = 1'b0;
    logic [2:0]  cfg_parity = 3'd0;
    logic        evt_ready = 1'b0;
    logic        evt_valid;
    logic [2:0]  evt_code;
    logic        evt_dir;
    logic [8:0]  evt_data;

    always #2.5 clk = ~clk;

    uartmon_top u_uartmon_top (
        .clk           (clk),
        .rst           (rst),
        .rx_line       (rx_line),
        .tx_line       (tx_line),
        .cfg_cpb       (cfg_cpb),
        .cfg_nbits     (cfg_nbits),
        .cfg_msb_first (cfg_msb_first),
        .cfg_parity    (cfg_parity),
        .evt_ready     (evt_ready),
        .evt_valid     (evt_valid),
        .evt_code      (evt_code),
        .evt_dir       (evt_dir),
        .evt_data      (evt_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int starts_out [2];
    bit sim_chk    = 1'b0;
    bit idle_event = 1'b0;
    bit in_idle    = 1'b0;

    logic [11:0] q_rx [$];
    logic [11:0] q_tx [$];
    string       r_rx [$];
    string       r_tx [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Consumer drops ready one cycle in five.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            evt_ready = ((cyc % 5) != 3);
        end
    end

    // Reference comparison on every clock where a transfer takes place.
    always @(negedge clk) begin
        logic [11:0] got;
        logic [11:0] exp;
        string       rq;
        if (!rst && in_idle && evt_valid) idle_event = 1'b1;
        if (!rst && evt_valid && evt_ready) begin
            got = {evt_code, evt_data};
            if (evt_dir == 1'b0) begin
                if (q_rx.size() == 0) check(1'b0, "R1 unexpected rx event", int'(got), 0);
                else begin
                    exp = q_rx.pop_front();
                    rq  = r_rx.pop_front();
                    check(got == exp, {rq, " rx"}, int'(got), int'(exp));
                end
            end else begin
                if (q_tx.size() == 0) check(1'b0, "R1 unexpected tx event", int'(got), 0);
                else begin
                    exp = q_tx.pop_front();
                    rq  = r_tx.pop_front();
                    check(got == exp, {rq, " tx"}, int'(got), int'(exp));
                end
            end
            if (evt_code == 3'd0 || evt_code == 3'd5) begin
                if (sim_chk && evt_dir)
                    check(starts_out[0] > starts_out[1], "R11 receive start first", starts_out[0], starts_out[1] + 1);
                starts_out[evt_dir]++;
            end
        end
    end

    task automatic push(input int dir, input int code, input int data, input string req);
        logic [11:0] v;
        v = {3'(code), 9'(data)};
        if (dir == 0) begin q_rx.push_back(v); r_rx.push_back(req); end
        else          begin q_tx.push_back(v); r_tx.push_back(req); end
    endtask

    task automatic drive_bit(input int dir, input logic v, input int n);
        if (dir == 0) rx_line = v; else tx_line = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input int dir, input int word, input bit bad_start,
                        input bit par_flip, input bit stop_v, input string req);
        int n, cpb, w, p, pm;
        bit msb;
        n   = int'(cfg_nbits);
        cpb = int'(cfg_cpb);
        msb = cfg_msb_first;
        pm  = int'(cfg_parity);
        w   = word & ((1 << n) - 1);
        case (pm)
            1: p = ($countones(w) % 2 == 0) ? 1 : 0;
            2: p = $countones(w) % 2;
            3: p = 0;
            4: p = 1;
            default: p = 0;
        endcase
        if (par_flip) p = 1 - p;
        if (bad_start) push(dir, 5, 1, "R8 bad start");
        else           push(dir, 0, 0, "R2 R12 start");
        push(dir, 1, w, req);
        if (pm != 0) push(dir, par_flip ? 3 : 2, p, "R6 parity");
        if (stop_v) push(dir, 4, 1, (pm == 0) ? "R7 R9 stop" : "R9 stop");
        else        push(dir, 6, 0, "R9 frame error");
        if (bad_start) begin
            drive_bit(dir, 1'b0, 2);
            drive_bit(dir, 1'b1, cpb - 2);
        end else begin
            drive_bit(dir, 1'b0, cpb);
        end
        for (int i = 0; i < n; i++) begin
            drive_bit(dir, msb ? 1'((w >> (n - 1 - i)) & 1) : 1'((w >> i) & 1), cpb);
        end
        if (pm != 0) drive_bit(dir, 1'(p), cpb);
        drive_bit(dir, stop_v, cpb);
        drive_bit(dir, 1'b1, 2 * cpb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check(evt_valid == 1'b0, "R11 reset valid low", int'(evt_valid), 0);
        rst = 1'b0;

        in_idle = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        in_idle = 1'b0;
        check(idle_event == 1'b0, "R1 idle line silent", int'(idle_event), 0);

        // 8-bit, LSB first, no parity, each line alone.
        send(0, 'hA5, 0, 0, 1, "R4 lsb data");
        send(1, 'h3C, 0, 0, 1, "R10 R4 tx data");

        // Both lines in step, even parity.
        cfg_parity = 3'd2;
        sim_chk = 1'b1;
        fork
            send(0, 'h5A, 0, 0, 1, "R10 rx data");
            send(1, 'h81, 0, 0, 1, "R10 tx data");
        join
        sim_chk = 1'b0;

        // Odd parity, wrong bit on transmit line, good frame on receive line.
        cfg_parity = 3'd1;
        fork
            send(0, 'h0F, 0, 0, 1, "R6 odd data");
            send(1, 'h07, 0, 1, 1, "R6 odd err data");
        join

        // 9-bit MSB first, always-one parity.
        cfg_nbits = 4'd9; cfg_msb_first = 1'b1; cfg_parity = 3'd4;
        send(0, 'h1A3, 0, 0, 1, "R5 msb 9-bit data");
        send(1, 'h0C1, 0, 1, 1, "R5 msb stick-one err");

        // 5-bit always-zero parity, upper bits masked.
        cfg_nbits = 4'd5; cfg_msb_first = 1'b0; cfg_parity = 3'd3;
        send(1, 'h15, 0, 1, 1, "R6 stick-zero data");
        send(0, 'hFF, 0, 0, 1, "R3 5-bit data");

        // 7-bit no parity, glitch start on receive line.
        cfg_nbits = 4'd7; cfg_parity = 3'd0;
        send(0, 'h55, 1, 0, 1, "R8 data after bad start");

        // 6-bit odd parity, framing error then a clean frame.
        cfg_nbits = 4'd6; cfg_parity = 3'd1; cfg_msb_first = 1'b1;
        send(1, 'h2B, 0, 0, 0, "R9 data before frame error");
        send(1, 'h11, 0, 0, 1, "R9 data after frame error");

        repeat (100) @(posedge clk);
        #1;
        check(q_rx.size() == 0, "R12 all rx events seen", q_rx.size(), 0);
        check(q_tx.size() == 0, "R10 all tx events seen", q_tx.size(), 0);
        summary();
        $finish;
    end
endmodule